// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns three asynchronous interrupt pins into clean, held request flags for an interrupt controller. It handles one non-maskable pin and two maskable request pins. Every pin is brought into the clock domain through a synchronizer. The non-maskable pin is watched for one edge polarity, which software selects. Each maskable pin can be set to sense a rising edge, a falling edge, a low level or a high level.

Once a request is detected, its flag stays set until the processor signals that it has taken an interrupt. For a maskable input, setting its mask bit also clears the flag. A level-sensed request stays set after the pin goes inactive again. The pin does not need to be held until service. Changing the non-maskable edge polarity turns that input deaf for a short, fixed window, so the change itself cannot raise a false request.

Configuration arrives on a one-cycle write strobe with a 1-bit address. Address 0, bit 0, is the non-maskable edge select. Address 1 holds the maskable sense fields and mask bits. Priority choice and vector generation are left to the consumer of the flags.

Top module: `extint_sense`

## Requirements
- R1: After reset, all pending flags are 0. Both maskable inputs are masked and set to low-level sense. The non-maskable input detects falling edges.
- R2: A pin change is seen through two synchronizer flops. The pending flag changes on the third rising clock edge after the pin changes, and not before.
- R3: Address 0 bit 0 selects the non-maskable edge: 1 means rising and 0 means falling. An edge of the other polarity leaves nmiPend unchanged.
- R4: Every write to address 0 reloads a blanking window. During the six clock edges after the write edge, no non-maskable detection can set nmiPend. A detection on the seventh edge sets it.
- R5: At address 1, bits [2n+1:2n] set the sense mode of maskable input n: 00 low level, 01 high level, 10 falling edge, 11 rising edge. Edges of the other kind, and the inactive level, set nothing.
- R6: Once a maskable request has been detected, its flag stays 1 after the pin returns to the inactive level. It stays 1 until an accept or a mask.
- R7: A one-cycle cpuAccept pulse clears every pending flag, in any sense mode, on the next edge, unless a new detection happens on that same edge.
- R8: At address 1, bit 4+n is the mask of maskable input n. While the mask is 1, the flag clears on the next edge and cannot be set. Edges that arrive while masked are lost.
- R9: When a detection and an accept (or nothing else) land on the same edge, the detection wins and the flag ends up 1. This covers edges, and levels that are still active.
- R10: A write that changes an input's sense mode discards that input's edge history. An edge still in flight in the synchronizer at the write does not raise a request under the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiPin | input | 1 | Asynchronous non-maskable interrupt pin |
| irqPin | input | 2 | Asynchronous maskable interrupt pins |
| cfgWrEn | input | 1 | One-cycle configuration write strobe |
| cfgAddr | input | 1 | 0: non-maskable edge select, 1: sense modes and masks |
| cfgWrData | input | 6 | Write data |
| cpuAccept | input | 1 | Pulse when the processor accepts any interrupt |
| nmiPend | output | 1 | Non-maskable request pending |
| irqPend | output | 2 | Maskable requests pending |

## Verification
The properties assume cfgWrEn is a single-cycle strobe and cpuAccept is a pulse. They also assume pins only change away from the clock edge, so the synchronizer delay is exactly two edges. The bench drives every pin, strobe and accept on the falling clock edge. It holds each pin level for at least three cycles, except in the tests that deliberately place an edge inside the blanking window or the synchronizer pipeline. In those tests the pin timing is counted edge by edge from the write strobe, so each detection falls on a known edge relative to that strobe.

// File: rtl/extint_sense_pkg.sv
package extint_sense_pkg;
  parameter int unsigned IRQ_NUM = 2;
  localparam int unsigned CFG_W = 3 * IRQ_NUM;
  localparam logic ADDR_NMI = 1'b0;
  localparam logic ADDR_IRQ = 1'b1;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  typedef struct packed {
    logic                      nmiDetEn;
    logic                      nmiRise;
    logic                      accept;
    logic [IRQ_NUM-1:0]        histClr;
    logic [IRQ_NUM-1:0]        irqMask;
    logic [IRQ_NUM-1:0][1:0]   irqMode;
  } ctrlStrobes_t;
endpackage

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_sense_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             cpuAccept,
  output ctrlStrobes_t     strobes
);
  localparam int unsigned CNT_W = $clog2(BLANK_CYCLES + 1);

  logic                    nmiRiseQ;
  logic [IRQ_NUM-1:0][1:0] modeQ;
  logic [IRQ_NUM-1:0][1:0] modeNext;
  logic [IRQ_NUM-1:0]      maskQ;
  logic [IRQ_NUM-1:0]      maskNext;
  logic [CNT_W-1:0]        blankCnt;
  logic                    wrNmi;
  logic                    wrIrq;

  assign wrNmi = cfgWrEn && (cfgAddr == ADDR_NMI);
  assign wrIrq = cfgWrEn && (cfgAddr == ADDR_IRQ);

  for (genvar n = 0; n < IRQ_NUM; n++) begin : gField
    assign modeNext[n] = cfgWrData[2*n+1 -: 2];
    assign maskNext[n] = cfgWrData[2*IRQ_NUM + n];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiRiseQ <= 1'b0;
      modeQ    <= '{default: SENSE_LOW};
      maskQ    <= '1;
      blankCnt <= '0;
    end else begin
      if (wrNmi) begin
        nmiRiseQ <= cfgWrData[0];
        blankCnt <= CNT_W'(BLANK_CYCLES);
      end else if (blankCnt != '0) begin
        blankCnt <= blankCnt - 1'b1;
      end
      if (wrIrq) begin
        modeQ <= modeNext;
        maskQ <= maskNext;
      end
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.nmiDetEn = (blankCnt == '0);
    strobes.nmiRise  = nmiRiseQ;
    strobes.accept   = cpuAccept;
    strobes.irqMask  = maskQ;
    strobes.irqMode  = modeQ;
    for (int n = 0; n < IRQ_NUM; n++) begin
      strobes.histClr[n] = wrIrq && (modeNext[n] != modeQ[n]);
    end
  end
endmodule

// File: rtl/extint_sense_dp.sv
module extint_sense_dp
  import extint_sense_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiPin,
  input  logic [IRQ_NUM-1:0] irqPin,
  input  ctrlStrobes_t       strobes,
  output logic               nmiPend,
  output logic [IRQ_NUM-1:0] irqPend
);
  localparam int unsigned PIN_NUM = IRQ_NUM + 1;

  logic [PIN_NUM-1:0] pinVec;
  logic [PIN_NUM-1:0] syncA;
  logic [PIN_NUM-1:0] syncB;
  logic [PIN_NUM-1:0] prevB;
  logic [PIN_NUM-1:0] histClrVec;
  logic [PIN_NUM-1:0] riseDet;
  logic [PIN_NUM-1:0] fallDet;
  logic               nmiHit;

  assign pinVec     = {irqPin, nmiPin};
  assign histClrVec = {strobes.histClr, 1'b0};
  assign riseDet    = syncB & ~prevB;
  assign fallDet    = ~syncB & prevB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinVec;
      syncB <= syncA;
      for (int i = 0; i < PIN_NUM; i++) begin
        prevB[i] <= histClrVec[i] ? syncA[i] : syncB[i];
      end
    end
  end

  assign nmiHit = strobes.nmiDetEn &&
                  (strobes.nmiRise ? riseDet[0] : fallDet[0]);

  always_ff @(posedge clk) begin
    if (!rstN)                nmiPend <= 1'b0;
    else if (nmiHit)          nmiPend <= 1'b1;
    else if (strobes.accept)  nmiPend <= 1'b0;
  end

  for (genvar n = 0; n < IRQ_NUM; n++) begin : gIrq
    logic hit;
    always_comb begin
      unique case (senseMode_e'(strobes.irqMode[n]))
        SENSE_LOW:  hit = !syncB[n+1];
        SENSE_HIGH: hit = syncB[n+1];
        SENSE_FALL: hit = fallDet[n+1];
        default:    hit = riseDet[n+1];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)                   irqPend[n] <= 1'b0;
      else if (strobes.irqMask[n]) irqPend[n] <= 1'b0;
      else if (hit)                irqPend[n] <= 1'b1;
      else if (strobes.accept)     irqPend[n] <= 1'b0;
    end
  end
endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_sense_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiPin,
  input  logic [IRQ_NUM-1:0] irqPin,
  input  logic               cfgWrEn,
  input  logic               cfgAddr,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic               cpuAccept,
  output logic               nmiPend,
  output logic [IRQ_NUM-1:0] irqPend
);
  ctrlStrobes_t strobes;

  extint_sense_ctrl #(.BLANK_CYCLES(BLANK_CYCLES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cpuAccept (cpuAccept),
    .strobes   (strobes)
  );

  extint_sense_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .nmiPin  (nmiPin),
    .irqPin  (irqPin),
    .strobes (strobes),
    .nmiPend (nmiPend),
    .irqPend (irqPend)
  );
endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk
  import extint_sense_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic               cfgAddr,
  input logic               cpuAccept,
  input logic               nmiPend,
  input logic [IRQ_NUM-1:0] irqPend,
  input logic [IRQ_NUM-1:0] irqMask
);
  localparam int unsigned CNT_W = $clog2(BLANK_CYCLES + 1);
  logic [CNT_W-1:0] chkCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                 chkCnt <= '0;
    else if (cfgWrEn && cfgAddr == ADDR_NMI)   chkCnt <= CNT_W'(BLANK_CYCLES);
    else if (chkCnt != '0)                     chkCnt <= chkCnt - 1'b1;
  end

  assert_nmi_blanked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt != '0) |=> !$rose(nmiPend));

  assert_nmi_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && !cpuAccept) |=> nmiPend);

  for (genvar n = 0; n < IRQ_NUM; n++) begin : gChk
    assert_mask_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      irqMask[n] |=> !irqPend[n]);

    assert_rise_unmasked_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqPend[n]) |-> $past(!irqMask[n]));

    assert_level_held_R6: assert property (@(posedge clk) disable iff (!rstN)
      (irqPend[n] && !cpuAccept && !irqMask[n]) |=> irqPend[n]);
  end
endmodule

bind extint_sense extint_sense_chk #(.BLANK_CYCLES(BLANK_CYCLES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgAddr   (cfgAddr),
  .cpuAccept (cpuAccept),
  .nmiPend   (nmiPend),
  .irqPend   (irqPend),
  .irqMask   (strobes.irqMask)
);

// File: tb/extint_sense_test.sv
module extint_sense_test;
  import extint_sense_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiPin = 1'b1;
  logic [IRQ_NUM-1:0] irqPin = '1;
  logic cfgWrEn = 1'b0;
  logic cfgAddr = 1'b0;
  logic [CFG_W-1:0] cfgWrData = '0;
  logic cpuAccept = 1'b0;
  logic nmiPend;
  logic [IRQ_NUM-1:0] irqPend;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  extint_sense uut (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .irqPin(irqPin),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cpuAccept(cpuAccept), .nmiPend(nmiPend), .irqPend(irqPend)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // data layout: [1:0] irq0 mode, [3:2] irq1 mode, [4] mask0, [5] mask1
  task automatic wrCfg(input logic addr, input logic [CFG_W-1:0] data);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgWrData = data;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic accept();
    cpuAccept = 1'b1;
    tick(1);
    cpuAccept = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 nmi after reset", 8'(nmiPend), 8'h0);
    chk("R1 irq after reset", 8'(irqPend), 8'h0);
    irqPin = 2'b00;  // low-level default, but masked
    tick(5);
    chk("R1 masked by default", 8'(irqPend), 8'h0);
    nmiPin = 1'b0; tick(2);
    chk("R2 not yet after two edges", 8'(nmiPend), 8'h0);
    tick(1);
    chk("R1 default falling edge sets nmi", 8'(nmiPend), 8'h1);
  endtask

  task automatic testNmiEdge();
    accept(); tick(1);
    chk("R7 accept clears nmi", 8'(nmiPend), 8'h0);
    nmiPin = 1'b1; tick(5);
    chk("R3 rising ignored in falling mode", 8'(nmiPend), 8'h0);
  endtask

  task automatic testBlanking();
    wrCfg(ADDR_NMI, 6'h01);  // rising; now one negedge after write edge
    nmiPin = 1'b0; tick(3);
    nmiPin = 1'b1; tick(8);  // would set on 6th edge after write
    chk("R4 edge inside window ignored", 8'(nmiPend), 8'h0);
    wrCfg(ADDR_NMI, 6'h01);
    nmiPin = 1'b0; tick(4);
    nmiPin = 1'b1; tick(2);  // sets on 7th edge after write
    chk("R2 sync latency after window", 8'(nmiPend), 8'h0);
    tick(1);
    chk("R4 edge on seventh edge accepted", 8'(nmiPend), 8'h1);
    accept(); tick(1);
    nmiPin = 1'b0; tick(5);
    chk("R3 falling ignored in rising mode", 8'(nmiPend), 8'h0);
  endtask

  task automatic testHighFall();
    irqPin = 2'b00; tick(3);
    wrCfg(ADDR_IRQ, 6'b00_10_01);  // irq1 falling, irq0 high
    tick(5);
    chk("R5 inactive level and no edge", 8'(irqPend), 8'h0);
    irqPin[0] = 1'b1; tick(3);
    chk("R5 high level sets irq0", 8'(irqPend), 8'h1);
    irqPin[0] = 1'b0; tick(5);
    chk("R6 level request held after pin drops", 8'(irqPend), 8'h1);
    accept(); tick(1);
    chk("R7 accept clears held level request", 8'(irqPend), 8'h0);
    irqPin[1] = 1'b1; tick(5);
    chk("R5 rising ignored in falling mode", 8'(irqPend), 8'h0);
    irqPin[1] = 1'b0; tick(3);
    chk("R5 falling sets irq1", 8'(irqPend), 8'h2);
    accept(); tick(1);
  endtask

  task automatic testLowRise();
    wrCfg(ADDR_IRQ, 6'b00_11_00);  // irq1 rising, irq0 low
    tick(3);
    chk("R5 low level sets irq0", 8'(irqPend), 8'h1);
    accept(); tick(1);
    chk("R9 active level wins over accept", 8'(irqPend), 8'h1);
    irqPin[0] = 1'b1; tick(3);
    accept(); tick(1);
    chk("R7 accept clears after level gone", 8'(irqPend), 8'h0);
    irqPin[1] = 1'b1; tick(3);
    chk("R5 rising sets irq1", 8'(irqPend), 8'h2);
  endtask

  task automatic testMask();
    wrCfg(ADDR_IRQ, 6'b10_11_00);  // mask irq1
    tick(1);
    chk("R8 mask clears pending", 8'(irqPend), 8'h0);
    irqPin[1] = 1'b0; tick(4);
    irqPin[1] = 1'b1; tick(4);
    chk("R8 masked edge not latched", 8'(irqPend), 8'h0);
    wrCfg(ADDR_IRQ, 6'b00_11_00);
    tick(4);
    chk("R8 edge during mask is lost", 8'(irqPend), 8'h0);
  endtask

  task automatic testAcceptRace();
    irqPin[1] = 1'b0; tick(4);
    irqPin[1] = 1'b1; tick(3);
    chk("R5 rising sets irq1 again", 8'(irqPend), 8'h2);
    irqPin[1] = 1'b0; tick(4);
    irqPin[1] = 1'b1; tick(2);
    accept();  // accept on the same edge as the new detection
    chk("R9 new edge wins over accept", 8'(irqPend), 8'h2);
    accept(); tick(1);
    chk("R7 accept clears edge request", 8'(irqPend), 8'h0);
  endtask

  task automatic testHistory();
    irqPin[1] = 1'b0; tick(1);
    wrCfg(ADDR_IRQ, 6'b00_10_00);  // irq1 falling, pin already low
    tick(4);
    accept(); tick(1);
    chk("R10 setup clear", 8'(irqPend), 8'h0);
    irqPin[1] = 1'b1; tick(1);
    wrCfg(ADDR_IRQ, 6'b00_11_00);  // switch to rising while edge in flight
    tick(5);
    chk("R10 in-flight edge discarded on mode change", 8'(irqPend), 8'h0);
    irqPin[1] = 1'b0; tick(4);
    irqPin[1] = 1'b1; tick(3);
    chk("R10 later edge detected normally", 8'(irqPend), 8'h2);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testNmiEdge();
    testBlanking();
    testHighFall();
    testLowRise();
    testMask();
    testAcceptRace();
    testHistory();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20ns * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule